// File: doc/BRIEF.md
# Auto-Reload Timer with Capture and PWM

This block is an up-counting timer driven by a one-cycle clock-enable input (`tick`). A power-of-two prescaler sits in front of it. The counter runs in one of two modes:

- **Reload mode:** when the counter wraps past its top value it restarts from a programmable reload value instead of zero. This sets both the period and the floor of a pulse-width output.
- **Capture mode:** the counter runs freely from zero. An edge on the external capture pin, after it has been synchronised, copies the live count into the same register that reload mode uses as its reload value.

In both modes the PWM output is driven high when the counter wraps and driven low when it reaches the compare value.

Software works the block through a small register bus with a combinational read. Three sticky event flags (wrap, compare match, pin edge) each raise an interrupt request when the matching enable bit is set. A load command copies the reload register into the counter. The load command works whether the counter is running or stopped.

Top module: `arl_timer`

## Requirements
- R1: After reset every register reads 0 at bus addresses 0 to 5, and `pwm_out`, `irq_ovf`, `irq_cmp` and `irq_edge` are 0.
- R2: When the run bit (control register, address 0, bit 7) is 0, both the counter and the prescaler hold their values whatever `tick` does. When it is 1, each `tick` advances the prescaler.
- R3: The ratio field in bits 7:5 of the configuration register (address 2) selects division by 2^n. The counter steps on a tick when the prescaler's low n bits are all ones. The prescaler is never cleared by a change of ratio, only by reset.
- R4: Writing 1 to the load bit (address 0, bit 6) copies the reload/capture register (address 3) into the counter at that clock edge, whether or not the counter is running. The load bit always reads back as 0, and the counter is readable at address 5.
- R5: With the mode field (address 0, bits 1:0) set to 00, 10 or 11, a step taken at FFh loads the reload/capture register and sets the wrap flag (status register, address 1, bit 2).
- R6: With the mode field set to 01, the counter wraps from FFh to 00h and sets the wrap flag.
- R7: The edge-select field (address 2, bits 1:0) picks the active pin edge: 00 none, 01 rising, 10 falling, 11 both. An active edge sets the edge flag (status bit 0) three clocks after the pin changes. In mode 01 the same edge also copies the counter into the reload/capture register; in the other modes that register is left alone.
- R8: `pwm_out` goes high on a wrap step and low on a step whose new count equals the compare register (address 4), with the compare taking priority. Over one reload period with reload value r and compare value c, the output is high for c−r steps if c>r, for 0 steps if c=r, and for 256−r steps if c<r.
- R9: A step whose new count equals the compare register sets the compare flag (status bit 1).
- R10: The flags are sticky. A status write clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1.
- R11: `irq_ovf`, `irq_cmp` and `irq_edge` are each the matching flag ANDed with its enable bit (address 0, bits 5, 4 and 3 respectively).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable, one pulse per input clock period |
| cap_pin | input | 1 | External capture/edge pin (asynchronous) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Register read data (combinational on address) |
| pwm_out | output | 1 | Pulse-width modulated output |
| irq_ovf | output | 1 | Wrap/reload interrupt request |
| irq_cmp | output | 1 | Compare-match interrupt request |
| irq_edge | output | 1 | Pin-edge interrupt request |

## Verification
A wrong prescaler phase shows up within one sweep of the division ratios. The counter read back after a fixed number of ticks then misses the arithmetic count of phase matches. A wrong reload or compare decision changes the number of high PWM cycles within the first full period after the first wrap, so a measurement over exactly one period exposes it. A capture or edge-select fault leaves a stale value in the reload/capture register, or a wrong edge flag, four clocks after the pin moves.

// File: rtl/arl_timer_pkg.sv
package arl_timer_pkg;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
   localparam logic [ADDR_W-1:0] A_CFG    = 3'd2;
   localparam logic [ADDR_W-1:0] A_RLDCAP = 3'd3;
   localparam logic [ADDR_W-1:0] A_CMP    = 3'd4;
   localparam logic [ADDR_W-1:0] A_COUNT  = 3'd5;

   localparam int B_RUN     = 7;
   localparam int B_LOAD    = 6;
   localparam int B_OVF_IE  = 5;
   localparam int B_CMP_IE  = 4;
   localparam int B_EDGE_IE = 3;

   localparam int F_OVF  = 2;
   localparam int F_CMP  = 1;
   localparam int F_EDGE = 0;
   localparam int N_FLAGS = 3;

   localparam int PS_MSB = 7;

   typedef enum logic [1:0] {
      MODE_RELOAD  = 2'b00,
      MODE_CAPTURE = 2'b01,
      MODE_RLD_B   = 2'b10,
      MODE_RLD_C   = 2'b11
   } arl_mode_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } arl_edge_e;

   typedef struct packed {
      logic      run;
      logic      ovf_ie;
      logic      cmp_ie;
      logic      edge_ie;
      arl_mode_e mode;
   } arl_ctrl_t;

endpackage

// File: rtl/arl_prescaler.sv
module arl_prescaler #(
   parameter int PRESC_W = 7,
   parameter int PS_W    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            run,
   input  logic [PS_W-1:0] ratio,
   output logic            step
);

   localparam int MAX_RATIO = (1 << PS_W) - 1;

   generate
      if (MAX_RATIO > PRESC_W) begin : g_bad_ratio_width
         $error("arl_prescaler: ratio field can select more bits than the prescaler has");
      end
   endgenerate

   logic [PRESC_W-1:0] phase_q;
   logic [PRESC_W-1:0] mask;
   logic               advance;

   always_comb begin
      for (int i = 0; i < PRESC_W; i++) begin
         mask[i] = (int'(ratio) > i);
      end
   end

   assign advance = tick & run;
   assign step    = advance & ((phase_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (advance) begin
         phase_q <= phase_q + 1'b1;
      end
   end

   // R2: the prescaler holds whenever it is not advanced
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> phase_q == $past(phase_q));

endmodule

// File: rtl/arl_edge_detect.sv
module arl_edge_detect
   import arl_timer_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  arl_edge_e sel,
   output logic      evt
);

   logic level;
   logic prev_q;
   logic rise;
   logic fall;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign level = pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= SYNC_STAGES'({sync_q, pin});
         end
         assign level = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

   always_comb begin
      unique case (sel)
         EDGE_NONE: evt = 1'b0;
         EDGE_RISE: evt = rise;
         EDGE_FALL: evt = fall;
         EDGE_BOTH: evt = rise | fall;
         default:   evt = 1'b0;
      endcase
   end

   // R7: an event always coincides with a level change on the synchronised pin
   p_edge_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> (level != prev_q));

endmodule

// File: rtl/arl_count_core.sv
module arl_count_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             auto_reload,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_evt,
   output logic             cmp_evt,
   output logic             pwm
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic             at_top;
   logic             do_step;
   logic [CNT_W-1:0] nxt;

   assign at_top  = (cnt == CNT_TOP);
   assign do_step = step & ~load;
   assign nxt     = at_top ? (auto_reload ? reload_val : '0) : cnt + 1'b1;

   assign wrap_evt = do_step & at_top;
   assign cmp_evt  = do_step & (nxt == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= reload_val;
      end else if (do_step) begin
         cnt <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm <= 1'b0;
      end else if (cmp_evt) begin
         pwm <= 1'b0;
      end else if (wrap_evt) begin
         pwm <= 1'b1;
      end
   end

   p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> cnt == $past(cnt));

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(reload_val));

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && auto_reload && cnt == CNT_TOP) |=> cnt == $past(reload_val));

   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !auto_reload && cnt == CNT_TOP) |=> cnt == '0);

   p_pwm_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt |=> !pwm);

   p_pwm_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_evt && !cmp_evt) |=> pwm);

endmodule

// File: rtl/arl_timer.sv
module arl_timer
   import arl_timer_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PRESC_W     = 7,
   parameter int PS_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cap_pin,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              pwm_out,
   output logic              irq_ovf,
   output logic              irq_cmp,
   output logic              irq_edge
);

   generate
      if (CNT_W < 8) begin : g_bad_cnt_w
         $error("arl_timer: register fields need CNT_W of at least 8");
      end
      if (PS_W > 5 || PS_W < 1) begin : g_bad_ps_w
         $error("arl_timer: ratio field must fit bits 7 down to 3");
      end
   endgenerate

   arl_ctrl_t           ctrl_q;
   logic [PS_W-1:0]     ratio_q;
   arl_edge_e           esel_q;
   logic [N_FLAGS-1:0]  flag_q;
   logic [N_FLAGS-1:0]  flag_nxt;
   logic [CNT_W-1:0]    rldcap_q;
   logic [CNT_W-1:0]    cmp_q;

   logic                wr_ctrl, wr_stat, wr_cfg, wr_rld, wr_cmp;
   logic                load_pulse;
   logic                step;
   logic                edge_evt;
   logic                cap_evt;
   logic                wrap_evt;
   logic                cmp_evt;
   logic                auto_reload;
   logic [CNT_W-1:0]    cnt;

   assign wr_ctrl    = bus_we && (bus_addr == A_CTRL);
   assign wr_stat    = bus_we && (bus_addr == A_STAT);
   assign wr_cfg     = bus_we && (bus_addr == A_CFG);
   assign wr_rld     = bus_we && (bus_addr == A_RLDCAP);
   assign wr_cmp     = bus_we && (bus_addr == A_CMP);
   assign load_pulse = wr_ctrl && bus_wdata[B_LOAD];

   assign auto_reload = (ctrl_q.mode != MODE_CAPTURE);
   assign cap_evt     = edge_evt && !auto_reload;

   arl_prescaler #(
      .PRESC_W (PRESC_W),
      .PS_W    (PS_W)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .run   (ctrl_q.run),
      .ratio (ratio_q),
      .step  (step)
   );

   arl_edge_detect #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cap_pin),
      .sel   (esel_q),
      .evt   (edge_evt)
   );

   arl_count_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .load        (load_pulse),
      .reload_val  (rldcap_q),
      .auto_reload (auto_reload),
      .cmp_val     (cmp_q),
      .cnt         (cnt),
      .wrap_evt    (wrap_evt),
      .cmp_evt     (cmp_evt),
      .pwm         (pwm_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.run     <= bus_wdata[B_RUN];
         ctrl_q.ovf_ie  <= bus_wdata[B_OVF_IE];
         ctrl_q.cmp_ie  <= bus_wdata[B_CMP_IE];
         ctrl_q.edge_ie <= bus_wdata[B_EDGE_IE];
         ctrl_q.mode    <= arl_mode_e'(bus_wdata[1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= '0;
         esel_q  <= EDGE_NONE;
      end else if (wr_cfg) begin
         ratio_q <= bus_wdata[PS_MSB -: PS_W];
         esel_q  <= arl_edge_e'(bus_wdata[1:0]);
      end
   end

   always_comb begin
      flag_nxt = flag_q;
      if (wr_stat) flag_nxt = flag_q & bus_wdata[N_FLAGS-1:0];
      flag_nxt[F_OVF]  = flag_nxt[F_OVF]  | wrap_evt;
      flag_nxt[F_CMP]  = flag_nxt[F_CMP]  | cmp_evt;
      flag_nxt[F_EDGE] = flag_nxt[F_EDGE] | edge_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rldcap_q <= '0;
      end else if (cap_evt) begin
         rldcap_q <= cnt;
      end else if (wr_rld) begin
         rldcap_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (wr_cmp) cmp_q <= bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL: begin
            bus_rdata[B_RUN]     = ctrl_q.run;
            bus_rdata[B_OVF_IE]  = ctrl_q.ovf_ie;
            bus_rdata[B_CMP_IE]  = ctrl_q.cmp_ie;
            bus_rdata[B_EDGE_IE] = ctrl_q.edge_ie;
            bus_rdata[1:0]       = ctrl_q.mode;
         end
         A_STAT:   bus_rdata[N_FLAGS-1:0] = flag_q;
         A_CFG: begin
            bus_rdata[PS_MSB -: PS_W] = ratio_q;
            bus_rdata[1:0]            = esel_q;
         end
         A_RLDCAP: bus_rdata = rldcap_q;
         A_CMP:    bus_rdata = cmp_q;
         A_COUNT:  bus_rdata = cnt;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_ovf  = flag_q[F_OVF]  & ctrl_q.ovf_ie;
   assign irq_cmp  = flag_q[F_CMP]  & ctrl_q.cmp_ie;
   assign irq_edge = flag_q[F_EDGE] & ctrl_q.edge_ie;

   // R10: without a status write no flag ever falls
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> (flag_q & $past(flag_q)) == $past(flag_q));

   // R7: a capture event stores the count seen at that edge
   p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> rldcap_q == $past(cnt));

   // R5: wraps raise the flag on the following cycle
   p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> flag_q[F_OVF]);

endmodule

// File: tb/arl_timer_tb.sv
`timescale 1ns/1ps
module arl_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       cap_pin = 1'b0;
   logic       bus_we = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       pwm_out, irq_ovf, irq_cmp, irq_edge;

   int n_chk = 0;
   int n_bad = 0;
   int run_ticks = 0;

   always #10 clk = ~clk;

   arl_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cap_pin   (cap_pin),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out),
      .irq_ovf   (irq_ovf),
      .irq_cmp   (irq_cmp),
      .irq_edge  (irq_edge)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int d);
      @(negedge clk);
      bus_addr = a;
      #1 d = int'(bus_rdata);
   endtask

   task automatic ticks(input int n, input bit running);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      if (running) run_ticks += n;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int steps(input int p0, input int n, input int ps);
      int mask = (1 << ps) - 1;
      int c = 0;
      for (int j = 0; j < n; j++) begin
         if ((((p0 + j) % 128) & mask) == mask) c++;
      end
      return c;
   endfunction

   task automatic pwm_case(input int r, input int c, input int m);
      int p = 256 - r;
      int high = 0;
      int exp_high;
      int v;
      wr(3'd0, 8'(m));
      wr(3'd2, 8'h00);
      wr(3'd3, 8'(r));
      wr(3'd4, 8'(c));
      wr(3'd0, 8'(m | 8'h40));
      wr(3'd1, 8'h00);
      wr(3'd0, 8'(m | 8'h80));
      @(negedge clk);
      tick = 1'b1;
      for (int s = 1; s < 2 * p; s++) begin
         @(negedge clk);
         if (s >= p && pwm_out) high++;
      end
      tick = 1'b0;
      run_ticks += 2 * p - 1;
      wr(3'd0, 8'(m));
      exp_high = (c > r) ? (c - r) : ((c == r) ? 0 : p);
      chk("R8 pwm high steps", high, exp_high);
      rd(3'd1, v);
      chk("R9/R5 status after period", v, 4 | ((c >= r) ? 2 : 0));
      rd(3'd5, v);
      chk("R5 counter at end of period", v, 255);
      rd(3'd3, v);
      chk("R5 reload register unchanged", v, r);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int v;
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk("R1 register reset", v, 0);
      end
      chk("R1 pwm reset", int'(pwm_out), 0);
      chk("R1 irq reset", int'({irq_ovf, irq_cmp, irq_edge}), 0);

      // R4: load while stopped
      wr(3'd3, 8'hF0);
      wr(3'd0, 8'h40);
      rd(3'd5, v);
      chk("R4 load copies reload", v, 8'hF0);
      rd(3'd0, v);
      chk("R4 load bit reads 0", v, 0);

      // R3: prescaler ratio sweep, phase carried across ratio changes
      for (int ps = 0; ps < 8; ps++) begin
         wr(3'd3, 8'h00);
         wr(3'd0, 8'h40);
         wr(3'd2, 8'(ps << 5));
         rd(3'd2, v);
         chk("R3 ratio field readback", v, ps << 5);
         wr(3'd0, 8'h80);
         p0 = run_ticks % 128;
         ticks(37, 1'b1);
         wr(3'd0, 8'h00);
         rd(3'd5, v);
         chk("R3 steps for ratio", v, steps(p0, 37, ps));
      end

      // R2: stop freezes counter and prescaler
      wr(3'd3, 8'h00);
      wr(3'd0, 8'h40);
      wr(3'd2, 8'h40);
      wr(3'd0, 8'h80);
      p0 = run_ticks % 128;
      ticks(5, 1'b1);
      wr(3'd0, 8'h00);
      ticks(9, 1'b0);
      rd(3'd5, v);
      chk("R2 frozen counter", v, steps(p0, 5, 2));
      wr(3'd0, 8'h80);
      ticks(6, 1'b1);
      wr(3'd0, 8'h00);
      rd(3'd5, v);
      chk("R2 prescaler resumed from held phase", v, steps(p0, 11, 2));

      // R8/R5/R9: PWM periods under several reload/compare pairs
      pwm_case(8'h00, 8'h80, 0);
      pwm_case(8'hC0, 8'hE0, 0);
      pwm_case(8'hF0, 8'hF0, 0);
      pwm_case(8'hF0, 8'h10, 0);
      pwm_case(8'hFE, 8'hFF, 2);
      pwm_case(8'h80, 8'hA0, 3);

      // R10/R11: sticky flags and interrupt gating (status now 6)
      wr(3'd1, 8'h05);
      rd(3'd1, v);
      chk("R10 write 0 clears only that flag", v, 4);
      wr(3'd1, 8'hFF);
      rd(3'd1, v);
      chk("R10 write 1 keeps flags", v, 4);
      wr(3'd0, 8'h30);
      idle(1);
      chk("R11 irq_ovf with enable", int'(irq_ovf), 1);
      chk("R11 irq_cmp with cleared flag", int'(irq_cmp), 0);
      wr(3'd1, 8'h00);
      idle(1);
      chk("R11 irq_ovf after clear", int'(irq_ovf), 0);

      // R7: capture on rising edge
      wr(3'd2, 8'h01);
      wr(3'd3, 8'h5A);
      wr(3'd0, 8'h41);
      wr(3'd1, 8'h00);
      @(negedge clk) cap_pin = 1'b1;
      idle(4);
      rd(3'd3, v);
      chk("R7 rising capture", v, 8'h5A);
      rd(3'd1, v);
      chk("R7 edge flag on rising", v, 1);

      // R7: falling ignored under rising select
      wr(3'd3, 8'h33);
      wr(3'd0, 8'h41);
      wr(3'd3, 8'h77);
      wr(3'd1, 8'h00);
      @(negedge clk) cap_pin = 1'b0;
      idle(4);
      rd(3'd3, v);
      chk("R7 falling ignored", v, 8'h77);
      rd(3'd1, v);
      chk("R7 no edge flag when ignored", v, 0);

      // R7: falling select
      wr(3'd2, 8'h02);
      @(negedge clk) cap_pin = 1'b1;
      idle(4);
      rd(3'd3, v);
      chk("R7 rising ignored under falling", v, 8'h77);
      @(negedge clk) cap_pin = 1'b0;
      idle(4);
      rd(3'd3, v);
      chk("R7 falling capture", v, 8'h33);
      rd(3'd1, v);
      chk("R7 edge flag on falling", v, 1);

      // R7: both edges
      wr(3'd2, 8'h03);
      wr(3'd3, 8'h44);
      wr(3'd0, 8'h41);
      wr(3'd3, 8'h00);
      @(negedge clk) cap_pin = 1'b1;
      idle(4);
      rd(3'd3, v);
      chk("R7 both: rising capture", v, 8'h44);
      wr(3'd3, 8'h00);
      @(negedge clk) cap_pin = 1'b0;
      idle(4);
      rd(3'd3, v);
      chk("R7 both: falling capture", v, 8'h44);

      // R7: no edges selected
      wr(3'd2, 8'h00);
      wr(3'd3, 8'h11);
      wr(3'd1, 8'h00);
      @(negedge clk) cap_pin = 1'b1;
      idle(4);
      @(negedge clk) cap_pin = 1'b0;
      idle(4);
      rd(3'd3, v);
      chk("R7 none selected keeps register", v, 8'h11);
      rd(3'd1, v);
      chk("R7 none selected no flag", v, 0);

      // R11: edge interrupt
      wr(3'd2, 8'h01);
      wr(3'd0, 8'h09);
      @(negedge clk) cap_pin = 1'b1;
      idle(4);
      chk("R11 irq_edge", int'(irq_edge), 1);

      // R7: reload mode sets flag but does not capture
      wr(3'd0, 8'h00);
      wr(3'd3, 8'h12);
      wr(3'd1, 8'h00);
      @(negedge clk) cap_pin = 1'b0;
      idle(4);
      @(negedge clk) cap_pin = 1'b1;
      idle(4);
      rd(3'd3, v);
      chk("R7 reload mode no capture", v, 8'h12);
      rd(3'd1, v);
      chk("R7 reload mode edge flag", v, 1);

      // R6: capture mode wraps to zero
      wr(3'd2, 8'h00);
      wr(3'd3, 8'hFE);
      wr(3'd0, 8'h41);
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h81);
      ticks(3, 1'b1);
      wr(3'd0, 8'h01);
      rd(3'd5, v);
      chk("R6 free-run wrap", v, 1);
      rd(3'd1, v);
      chk("R6 wrap flag", v, 4);
      rd(3'd3, v);
      chk("R6 register untouched by wrap", v, 8'hFE);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule